// File: doc/BRIEF.md
# Configurable LIFO Stack

This block is a last-in, first-out store built from one pointer register and a small synchronous storage array. A client pushes a data word with `push_i` or pops the most recent word with `pop_i`. A popped word comes back on `pop_data_o` one clock later, qualified by `pop_valid_o`. The block reports when it is full or empty. Requests it cannot honour are refused and recorded in sticky error flags: a push into a full stack, a pop from an empty stack, and a push and a pop asked for in the same cycle.

The pointer convention is chosen by the static input `conv_i`, which must be held steady while reset is asserted and after it. Bit 1 sets the direction of growth (0 grows toward higher addresses, 1 toward lower). Bit 0 sets what the pointer marks (0 marks the last occupied slot, 1 marks the next free slot). The convention fixes the reset value of the pointer and the order in which the pointer moves and the array is touched. The pointer is visible on `sp_o` as a two's-complement value, so the convention can be observed from outside.

Top module: `lifo_stack`

## Requirements
- R1: While reset is asserted and just after it, `empty_o`=1, `full_o`=0, `pop_valid_o`=0 and all three error flags are 0. `sp_o` reads -1 for `conv_i`=00, 0 for 01, DEPTH for 10 and DEPTH-1 for 11.
- R2: Words come back in the reverse of their push order. `pop_valid_o` is 1 in exactly the cycle after an accepted pop, and `pop_data_o` carries the popped word in that cycle.
- R3: With `conv_i`=00 (upward, pointer on the last occupied slot), an accepted push adds 1 to `sp_o` and stores the word at the new value. An accepted pop reads the slot at `sp_o` and then subtracts 1.
- R4: With `conv_i`=01 (upward, pointer on the next free slot), an accepted push stores the word at `sp_o` and then adds 1. An accepted pop subtracts 1 and then reads the slot at the new value.
- R5: With `conv_i`=10 and 11 (downward), the block behaves as in R3 and R4 with adding and subtracting swapped.
- R6: `empty_o` is 1 exactly when no words are held. `full_o` is 1 exactly when DEPTH words are held.
- R7: A push while `full_o`=1 is refused. `sp_o` and the stored words stay unchanged, and `overflow_o` becomes 1.
- R8: A pop while `empty_o`=1 (with no push) is refused. No `pop_valid_o` follows, `sp_o` stays unchanged, and `underflow_o` becomes 1.
- R9: A push and a pop in the same cycle set `collide_o`. The push is handled as if alone, under R7 if the stack is full, and the pop is dropped.
- R10: `overflow_o`, `underflow_o` and `collide_o` stay at 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_i | input | 2 | Pointer convention: bit 1 = downward growth, bit 0 = pointer on next free slot |
| push_i | input | 1 | Push request |
| push_data_i | input | DATA_W | Word to push |
| pop_i | input | 1 | Pop request |
| pop_data_o | output | DATA_W | Popped word |
| pop_valid_o | output | 1 | `pop_data_o` holds a word popped in the previous cycle |
| full_o | output | 1 | DEPTH words held |
| empty_o | output | 1 | No word held |
| overflow_o | output | 1 | Sticky: a push was refused |
| underflow_o | output | 1 | Sticky: a pop was refused |
| collide_o | output | 1 | Sticky: push and pop were requested together |
| sp_o | output | PW | Pointer value, two's complement |

## Verification
All four conventions are driven with the same pattern:
- a pop on an empty stack;
- a fill past capacity;
- a collision while full;
- a drain past empty;
- a short run of interleaved pushes and pops;
- a collision while empty.

The fill and drain expose an off-by-one in the reset value or in the full and empty limits. The interleaved run shows whether the array is read before or after the pointer moves, because a wrong order returns a stale or neighbouring word. The two collisions tell apart a push that is correctly handled alone from one that is dropped or allowed to overflow.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
   typedef enum logic [1:0] {
      CONV_UP_LAST = 2'b00,
      CONV_UP_NEXT = 2'b01,
      CONV_DN_LAST = 2'b10,
      CONV_DN_NEXT = 2'b11
   } lifo_conv_e;
endpackage

// File: rtl/lifo_ptr.sv
module lifo_ptr #(
   parameter int DEPTH = 8,
   parameter int AW    = 3,
   parameter int PW    = 5
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [1:0]    conv_i,
   input  logic          push_ok_i,
   input  logic          pop_ok_i,
   output logic [PW-1:0] sp_o,
   output logic [AW-1:0] waddr_o,
   output logic [AW-1:0] raddr_o,
   output logic          full_o,
   output logic          empty_o
);
   import lifo_pkg::*;

   logic          grow_up, mark_next;
   logic [PW-1:0] sp_q, sp_rst, sp_push, sp_pop, occ;

   assign grow_up   = ~conv_i[1];
   assign mark_next = conv_i[0];

   always_comb begin
      case (lifo_conv_e'(conv_i))
         CONV_UP_LAST: sp_rst = '1;
         CONV_UP_NEXT: sp_rst = '0;
         CONV_DN_LAST: sp_rst = PW'(DEPTH);
         default:      sp_rst = PW'(DEPTH - 1);
      endcase
   end

   assign sp_push = grow_up ? sp_q + PW'(1) : sp_q - PW'(1);
   assign sp_pop  = grow_up ? sp_q - PW'(1) : sp_q + PW'(1);

   // last-full: move then write on push, read then move on pop
   // next-empty: write then move on push, move then read on pop
   assign waddr_o = mark_next ? sp_q[AW-1:0]   : sp_push[AW-1:0];
   assign raddr_o = mark_next ? sp_pop[AW-1:0] : sp_q[AW-1:0];

   assign occ     = grow_up ? sp_q - sp_rst : sp_rst - sp_q;
   assign empty_o = (occ == '0);
   assign full_o  = (occ == PW'(DEPTH));
   assign sp_o    = sp_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sp_q <= sp_rst;
      else if (push_ok_i) sp_q <= sp_push;
      else if (pop_ok_i)  sp_q <= sp_pop;
   end

   AST_SP_MOVES_ON_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_ok_i |=> sp_q != $past(sp_q)); // R3
   AST_SP_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !push_ok_i && !pop_ok_i |=> $stable(sp_q)); // R7
endmodule

// File: rtl/lifo_mem.sv
module lifo_mem #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   parameter int AW     = 3
) (
   input  logic              clk_i,
   input  logic              we_i,
   input  logic [AW-1:0]     waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              re_i,
   input  logic [AW-1:0]     raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk_i) begin
         if (we_i && (waddr_i == AW'(g))) slot_q[g] <= wdata_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (re_i) rdata_o <= slot_q[raddr_i];
   end
endmodule

// File: rtl/lifo_flags.sv
module lifo_flags (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ovf_set_i,
   input  logic unf_set_i,
   input  logic col_set_i,
   output logic ovf_o,
   output logic unf_o,
   output logic col_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ovf_o <= 1'b0;
         unf_o <= 1'b0;
         col_o <= 1'b0;
      end else begin
         ovf_o <= ovf_o | ovf_set_i;
         unf_o <= unf_o | unf_set_i;
         col_o <= col_o | col_set_i;
      end
   end

   AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |=> ovf_o); // R10
   AST_UNF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unf_o |=> unf_o); // R10
   AST_COL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      col_o |=> col_o); // R10
endmodule

// File: rtl/lifo_stack.sv
module lifo_stack #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int PW    = AW + 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [1:0]        conv_i,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] pop_data_o,
   output logic              pop_valid_o,
   output logic              full_o,
   output logic              empty_o,
   output logic              overflow_o,
   output logic              underflow_o,
   output logic              collide_o,
   output logic [PW-1:0]     sp_o
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("lifo_stack: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("lifo_stack: DATA_W must be at least 1");
   end

   logic          push_ok, pop_ok;
   logic [AW-1:0] waddr, raddr;

   assign push_ok = push_i & ~full_o;
   assign pop_ok  = pop_i & ~push_i & ~empty_o;

   lifo_ptr #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_ptr (
      .clk_i(clk_i), .rst_ni(rst_ni), .conv_i(conv_i),
      .push_ok_i(push_ok), .pop_ok_i(pop_ok), .sp_o(sp_o),
      .waddr_o(waddr), .raddr_o(raddr), .full_o(full_o), .empty_o(empty_o)
   );

   lifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk_i(clk_i), .we_i(push_ok), .waddr_i(waddr), .wdata_i(push_data_i),
      .re_i(pop_ok), .raddr_i(raddr), .rdata_o(pop_data_o)
   );

   lifo_flags u_flags (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .ovf_set_i(push_i & full_o),
      .unf_set_i(pop_i & ~push_i & empty_o),
      .col_set_i(push_i & pop_i),
      .ovf_o(overflow_o), .unf_o(underflow_o), .col_o(collide_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pop_valid_o <= 1'b0;
      else         pop_valid_o <= pop_ok;
   end

   AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(full_o && empty_o)); // R6
   AST_PUSH_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i && full_o |=> $stable(sp_o) && overflow_o); // R7
   AST_POP_EMPTY_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i && !push_i && empty_o |=> !pop_valid_o && underflow_o && $stable(sp_o)); // R8
   AST_COLLIDE_DROPS_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i && pop_i |=> collide_o && !pop_valid_o); // R9
   AST_VALID_AFTER_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_valid_o |-> $past(pop_i) && !$past(push_i)); // R2
endmodule

// File: tb/lifo_stack_tb.sv
`timescale 1ns/1ps
module lifo_stack_tb_top;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 8;
   localparam int PW     = $clog2(DEPTH) + 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        conv = 2'b00;
   logic              push = 1'b0, pop = 1'b0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              rvalid, full, empty, ovf, unf, col;
   logic [PW-1:0]     sp;

   int checks = 0;
   int failures = 0;

   // reference model
   int                m_q[$];
   int                m_sp;
   bit                m_valid, m_ovf, m_unf, m_col;
   int                m_data;

   always #4 clk = ~clk;

   lifo_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .conv_i(conv), .push_i(push),
      .push_data_i(wdata), .pop_i(pop), .pop_data_o(rdata),
      .pop_valid_o(rvalid), .full_o(full), .empty_o(empty),
      .overflow_o(ovf), .underflow_o(unf), .collide_o(col), .sp_o(sp)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s conv=%0d actual=%0d expected=%0d", req, what, conv, act, exp);
      end
   endtask

   function automatic int sp_reset(input logic [1:0] c);
      case (c)
         2'b00:   return -1;
         2'b01:   return 0;
         2'b10:   return DEPTH;
         default: return DEPTH - 1;
      endcase
   endfunction

   function automatic string sp_req(input logic [1:0] c);
      if (c == 2'b00) return "R3";
      if (c == 2'b01) return "R4";
      return "R5";
   endfunction

   task automatic compare_all(input string tag);
      int act_sp;
      act_sp = int'($signed(sp));
      chk(act_sp == m_sp, sp_req(conv), {tag, " sp"}, act_sp, m_sp);
      chk(empty == (m_q.size() == 0), "R6", {tag, " empty"}, int'(empty), int'(m_q.size() == 0));
      chk(full == (m_q.size() == DEPTH), "R6", {tag, " full"}, int'(full), int'(m_q.size() == DEPTH));
      chk(ovf == m_ovf, "R7", {tag, " overflow"}, int'(ovf), int'(m_ovf));
      chk(unf == m_unf, "R8", {tag, " underflow"}, int'(unf), int'(m_unf));
      chk(col == m_col, "R9", {tag, " collide"}, int'(col), int'(m_col));
      chk(rvalid == m_valid, "R2", {tag, " pop_valid"}, int'(rvalid), int'(m_valid));
      if (m_valid)
         chk(int'(rdata) == m_data, "R2", {tag, " pop_data"}, int'(rdata), m_data);
   endtask

   task automatic do_reset(input logic [1:0] c);
      @(negedge clk);
      rst_n = 1'b0;
      push = 1'b0;
      pop = 1'b0;
      conv = c;
      m_q.delete();
      m_sp = sp_reset(c);
      m_valid = 0; m_ovf = 0; m_unf = 0; m_col = 0; m_data = 0;
      repeat (2) @(negedge clk);
      compare_all("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1 after reset");
   endtask

   task automatic step(input bit p, input bit q, input int d, input string tag);
      bit up;
      push = p;
      pop = q;
      wdata = DATA_W'(d);
      @(posedge clk);
      up = (conv[1] == 1'b0);
      m_valid = 0;
      if (p && q) m_col = 1;
      if (p) begin
         if (m_q.size() == DEPTH) m_ovf = 1;
         else begin
            m_q.push_back(d & 8'hFF);
            m_sp = up ? m_sp + 1 : m_sp - 1;
         end
      end else if (q) begin
         if (m_q.size() == 0) m_unf = 1;
         else begin
            m_data = m_q.pop_back();
            m_valid = 1;
            m_sp = up ? m_sp - 1 : m_sp + 1;
         end
      end
      @(negedge clk);
      push = 1'b0;
      pop = 1'b0;
      compare_all(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int m = 0; m < 4; m++) begin
         do_reset(2'(m));
         step(0, 1, 0, "R8 pop on empty");
         for (int i = 0; i <= DEPTH; i++)
            step(1, 0, m * 37 + i * 11 + 5, "R7 fill past capacity");
         step(1, 1, 8'hEE, "R9 collide while full");
         for (int i = 0; i <= DEPTH; i++)
            step(0, 1, 0, "R2 drain past empty");
         step(1, 0, 8'hA1 + m, "R4 interleave push");
         step(1, 0, 8'hB2 + m, "R4 interleave push");
         step(0, 1, 0, "R3 interleave pop");
         step(1, 0, 8'hC3 + m, "R5 interleave push");
         step(0, 0, 0, "R10 idle keeps flags");
         step(0, 1, 0, "R2 interleave pop");
         step(0, 1, 0, "R2 interleave pop");
         step(1, 1, 8'h5A, "R9 collide while empty");
         step(0, 1, 0, "R9 pushed word returns");
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule